// File: doc/BRIEF.md
# Memory Protection Entry Configuration Register File

This block keeps the programmable state of a physical memory protection unit: one configuration byte and one address register per protection entry, plus a three-bit machine security register. Software reaches the state through a single register port. A select input chooses a packed group of configuration bytes, one entry's address register, or the security register. An index names the group or entry, and a write strobe commits the write data at the next rising clock edge. Read data is combinational from the stored state.

Every write passes through the protection rules before it lands. A set lock bit freezes an entry. A locked top-of-range entry also freezes the address register of the entry below it. When lockdown mode is on, a different acceptance test applies, and a bypass bit overrides the locks on configuration bytes. The two policy bits in the security register are sticky, and the bypass bit cannot be turned on while any entry is locked. The stored values of all entries are driven in parallel to the address-matching logic downstream.

Top module: `pmp_cfg_regs`

## Requirements
- R1: After synchronous reset every configuration byte, every address register and the security register read as zero.
- R2: Select code 0 addresses configuration group g. Bits 8i+7:8i of that group hold the byte of entry g*(XLEN/8)+i. Each byte has read at bit 0, write at bit 1, execute at bit 2, match mode at bits 4:3 (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and lock at bit 7. Each entry's byte also appears on the parallel output at bits 8e+7:8e.
- R3: With lockdown (security bit 0) and bypass (security bit 2) both clear, a write to a configuration byte whose lock bit is set leaves that byte unchanged.
- R4: A group write is judged byte by byte: locked bytes keep their value while unlocked bytes in the same write update.
- R5: With the bypass bit set, every configuration byte write is accepted, locked or not.
- R6: With lockdown set and bypass clear, a configuration byte write is accepted only if the new byte has lock set and execute clear, or has lock clear and its read/write/execute field is not exactly write+execute (3'b110). Any other write is dropped.
- R7: Select code 1 addresses entry index's address register. A write is dropped when that entry's lock bit is set.
- R8: An address write to entry e is also dropped when entry e+1 is locked with match mode top-of-range. A locked entry e+1 in another mode does not block it.
- R9: Select code 2 addresses the security register: lockdown at bit 0, whitelist policy at bit 1, bypass at bit 2. Once set, lockdown and whitelist policy cannot be cleared by a write.
- R10: A write that tries to set the bypass bit while it is clear and any entry is locked leaves the bypass bit at zero.
- R11: A configuration group index or address index beyond the implemented entries is ignored on write and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe |
| csr_sel | input | 2 | 0 configuration group, 1 address register, 2 security register, 3 none |
| csr_idx | input | IDX_W | Group or entry index |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the current select and index |
| entry_cfg_o | output | 8*NUM_ENTRIES | All configuration bytes, entry e at bits 8e+7:8e |
| entry_addr_o | output | XLEN*NUM_ENTRIES | All address registers, entry e at word e |
| seccfg_o | output | 3 | Security register: bypass, whitelist policy, lockdown |

## Verification
The assertions assume that the select, index, strobe and data inputs carry known values on every clock edge after reset. They also assume that writes arrive one per cycle through the single port, so a freeze condition seen before an edge is the only thing that decides that edge's update. The stimulus changes inputs only on falling edges, keeps every input defined from the start of reset, and holds the strobe for exactly one rising edge per write. Lock, lockdown and bypass states are built up in a set order, so each acceptance rule is exercised with the other controls in a known state.

// File: rtl/pmpr_pkg.sv
package pmpr_pkg;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     amode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef struct packed {
        logic rlb;
        logic mmwp;
        logic mml;
    } sec_t;

    // Acceptance of one configuration byte write
    function automatic logic cfg_write_ok(cfg_t cur, cfg_t nxt, sec_t sec);
        logic ok;
        if (sec.rlb) begin
            ok = 1'b1;
        end else if (!sec.mml) begin
            ok = !cur.lock;
        end else begin
            ok = (nxt.lock && !nxt.x) ||
                 (!nxt.lock && ({nxt.x, nxt.w, nxt.r} != 3'b110));
        end
        return ok;
    endfunction

    // Acceptance of one address register write
    function automatic logic addr_write_ok(cfg_t own, cfg_t above);
        return !own.lock && !(above.lock && (above.amode == AM_TOR));
    endfunction

    // Next value of the security register on a write
    function automatic sec_t sec_update(sec_t cur, logic [2:0] wr, logic any_lock);
        sec_t nxt;
        nxt = sec_t'(wr);
        if (!cur.rlb && any_lock) begin
            nxt.rlb = 1'b0;
        end
        nxt.mml  = nxt.mml  | cur.mml;
        nxt.mmwp = nxt.mmwp | cur.mmwp;
        return nxt;
    endfunction

endpackage

// File: rtl/pmpr_cfg_reg.sv
module pmpr_cfg_reg
    import pmpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  cfg_t       wr_byte,
    input  sec_t       sec,
    output cfg_t       cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && cfg_write_ok(cfg_q, wr_byte, sec)) begin
            cfg_q <= wr_byte;
        end
    end
endmodule

// File: rtl/pmpr_addr_reg.sv
module pmpr_addr_reg
    import pmpr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_word,
    input  cfg_t            own_cfg,
    input  cfg_t            above_cfg,
    output logic [XLEN-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_en && addr_write_ok(own_cfg, above_cfg)) begin
            addr_q <= wr_word;
        end
    end
endmodule

// File: rtl/pmpr_sec_reg.sv
module pmpr_sec_reg
    import pmpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_bits,
    input  logic       any_lock,
    output sec_t       sec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else if (wr_en) begin
            sec_q <= sec_update(sec_q, wr_bits, any_lock);
        end
    end
endmodule

// File: rtl/pmpr_read_mux.sv
module pmpr_read_mux
    import pmpr_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 8
) (
    input  csr_sel_e        sel,
    input  logic [IDX_W-1:0] idx,
    input  cfg_t            cfg   [NUM_ENTRIES],
    input  logic [XLEN-1:0] addr  [NUM_ENTRIES],
    input  sec_t            sec,
    output logic [XLEN-1:0] rdata
);
    localparam int BPG = XLEN / 8;

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CFG: begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (idx == IDX_W'(e / BPG)) begin
                        rdata[8*(e % BPG) +: 8] = cfg[e];
                    end
                end
            end
            SEL_ADDR: begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (idx == IDX_W'(e)) begin
                        rdata = addr[e];
                    end
                end
            end
            SEL_SEC:  rdata = XLEN'(sec);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmp_cfg_regs.sv
module pmp_cfg_regs
    import pmpr_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        csr_wr,
    input  logic [1:0]                  csr_sel,
    input  logic [IDX_W-1:0]            csr_idx,
    input  logic [XLEN-1:0]             csr_wdata,
    output logic [XLEN-1:0]             csr_rdata,
    output logic [8*NUM_ENTRIES-1:0]    entry_cfg_o,
    output logic [XLEN*NUM_ENTRIES-1:0] entry_addr_o,
    output logic [2:0]                  seccfg_o
);
    localparam int BPG = XLEN / 8;

    csr_sel_e        sel;
    cfg_t            cfg_q  [NUM_ENTRIES];
    logic [XLEN-1:0] addr_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] lock_vec;
    sec_t            sec_q;

    assign sel = csr_sel_e'(csr_sel);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic cfg_we;
        logic addr_we;
        cfg_t above;

        assign cfg_we  = csr_wr && (sel == SEL_CFG)  && (csr_idx == IDX_W'(e / BPG));
        assign addr_we = csr_wr && (sel == SEL_ADDR) && (csr_idx == IDX_W'(e));

        if (e + 1 < NUM_ENTRIES) begin : g_above
            assign above = cfg_q[e+1];
        end else begin : g_top
            assign above = '0;
        end

        pmpr_cfg_reg u_cfg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_we),
            .wr_byte (cfg_t'(csr_wdata[8*(e % BPG) +: 8])),
            .sec     (sec_q),
            .cfg_q   (cfg_q[e])
        );

        pmpr_addr_reg #(.XLEN(XLEN)) u_addr (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (addr_we),
            .wr_word   (csr_wdata),
            .own_cfg   (cfg_q[e]),
            .above_cfg (above),
            .addr_q    (addr_q[e])
        );

        assign lock_vec[e] = cfg_q[e].lock;
        assign entry_cfg_o[8*e +: 8]       = cfg_q[e];
        assign entry_addr_o[XLEN*e +: XLEN] = addr_q[e];
    end

    pmpr_sec_reg u_sec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (csr_wr && (sel == SEL_SEC)),
        .wr_bits  (csr_wdata[2:0]),
        .any_lock (|lock_vec),
        .sec_q    (sec_q)
    );

    pmpr_read_mux #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .XLEN        (XLEN),
        .IDX_W       (IDX_W)
    ) u_rd (
        .sel   (sel),
        .idx   (csr_idx),
        .cfg   (cfg_q),
        .addr  (addr_q),
        .sec   (sec_q),
        .rdata (csr_rdata)
    );

    assign seccfg_o = sec_q;

endmodule

// File: rtl/pmpr_checker.sv
module pmpr_checker #(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [1:0]                  csr_sel,
    input logic [IDX_W-1:0]            csr_idx,
    input logic [XLEN-1:0]             csr_rdata,
    input logic [8*NUM_ENTRIES-1:0]    entry_cfg_o,
    input logic [XLEN*NUM_ENTRIES-1:0] entry_addr_o,
    input logic [2:0]                  seccfg_o
);
    logic any_lock;
    always_comb begin
        any_lock = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            any_lock = any_lock | entry_cfg_o[8*e+7];
        end
    end

    AST_MML_STICKY: assert property (@(posedge clk) disable iff (rst)
        seccfg_o[0] |=> seccfg_o[0]); // R9
    AST_MMWP_STICKY: assert property (@(posedge clk) disable iff (rst)
        seccfg_o[1] |=> seccfg_o[1]); // R9
    AST_BYPASS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!seccfg_o[2] && any_lock) |=> !seccfg_o[2]); // R10
    AST_OOR_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd1 && csr_idx >= IDX_W'(NUM_ENTRIES)) |-> (csr_rdata == '0)); // R11

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
        AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!seccfg_o[0] && !seccfg_o[2] && entry_cfg_o[8*e+7])
            |=> $stable(entry_cfg_o[8*e +: 8])); // R3
        AST_MML_NO_LX: assert property (@(posedge clk) disable iff (rst)
            (seccfg_o[0] && !seccfg_o[2])
            |=> (!(entry_cfg_o[8*e+7] && entry_cfg_o[8*e+2]) || $stable(entry_cfg_o[8*e +: 8]))); // R6
        AST_ADDR_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
            entry_cfg_o[8*e+7] |=> $stable(entry_addr_o[XLEN*e +: XLEN])); // R7
        if (e + 1 < NUM_ENTRIES) begin : g_tor
            AST_ADDR_TOR_HOLD: assert property (@(posedge clk) disable iff (rst)
                (entry_cfg_o[8*(e+1)+7] && entry_cfg_o[8*(e+1)+3 +: 2] == 2'd1)
                |=> $stable(entry_addr_o[XLEN*e +: XLEN])); // R8
        end
    end
endmodule

bind pmp_cfg_regs pmpr_checker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .XLEN        (XLEN),
    .IDX_W       (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .csr_sel      (csr_sel),
    .csr_idx      (csr_idx),
    .csr_rdata    (csr_rdata),
    .entry_cfg_o  (entry_cfg_o),
    .entry_addr_o (entry_addr_o),
    .seccfg_o     (seccfg_o)
);

// File: tb/pmp_cfg_regs_test.sv
module pmp_cfg_regs_test;
    localparam int N  = 16;
    localparam int XL = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_wr = 1'b0;
    logic [1:0]    csr_sel = 2'd3;
    logic [IW-1:0] csr_idx = '0;
    logic [XL-1:0] csr_wdata = '0;
    logic [XL-1:0] csr_rdata;
    logic [8*N-1:0]  entry_cfg_o;
    logic [XL*N-1:0] entry_addr_o;
    logic [2:0]    seccfg_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pmp_cfg_regs #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) uut (
        .clk (clk), .rst (rst), .csr_wr (csr_wr), .csr_sel (csr_sel),
        .csr_idx (csr_idx), .csr_wdata (csr_wdata), .csr_rdata (csr_rdata),
        .entry_cfg_o (entry_cfg_o), .entry_addr_o (entry_addr_o), .seccfg_o (seccfg_o)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  idx;
        logic [31:0] wdata;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd0,  32'h0B0A0907, 32'h0B0A0907, 8'd2},  // R2 packing
        '{2'd0, 8'd1,  32'h8D000003, 32'h8D000003, 8'd2},  // R2 entry7 locked TOR
        '{2'd0, 8'd1,  32'h00000001, 32'h8D000001, 8'd4},  // R4 per byte
        '{2'd1, 8'd0,  32'h0000DEAD, 32'h0000DEAD, 8'd7},  // R7 unlocked accepted
        '{2'd1, 8'd7,  32'h00001234, 32'h00000000, 8'd7},  // R7 own lock
        '{2'd1, 8'd6,  32'h00005555, 32'h00000000, 8'd8},  // R8 above TOR locked
        '{2'd1, 8'd5,  32'h00006666, 32'h00006666, 8'd8},  // R8 above unlocked
        '{2'd0, 8'd3,  32'h00009000, 32'h00009000, 8'd3},  // R3 lock entry13 NA4
        '{2'd1, 8'd12, 32'h0000ABCD, 32'h0000ABCD, 8'd8},  // R8 above locked NA4
        '{2'd1, 8'd13, 32'h00000001, 32'h00000000, 8'd7},  // R7
        '{2'd0, 8'd3,  32'h00000000, 32'h00009000, 8'd3},  // R3 locked byte kept
        '{2'd2, 8'd0,  32'h00000004, 32'h00000000, 8'd10}, // R10
        '{2'd2, 8'd0,  32'h00000001, 32'h00000001, 8'd9},  // R9 set lockdown
        '{2'd2, 8'd0,  32'h00000000, 32'h00000001, 8'd9},  // R9 sticky
        '{2'd2, 8'd0,  32'h00000002, 32'h00000003, 8'd9},  // R9
        '{2'd2, 8'd0,  32'h00000000, 32'h00000003, 8'd9},  // R9
        '{2'd0, 8'd0,  32'h83060086, 32'h830A0007, 8'd6},  // R6 mixed
        '{2'd0, 8'd1,  32'h01000001, 32'h01000001, 8'd6},  // R6 relock path
        '{2'd0, 8'd4,  32'hFFFFFFFF, 32'h00000000, 8'd11}, // R11
        '{2'd1, 8'd16, 32'h0000FFFF, 32'h00000000, 8'd11}, // R11
        '{2'd1, 8'd200,32'h0000FFFF, 32'h00000000, 8'd11}  // R11
    };

    task automatic check(input logic [31:0] act, input logic [31:0] expv, input int req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] i, input logic [31:0] d);
        @(negedge clk);
        csr_sel = s; csr_idx = i; csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
        #1;
    endtask

    task automatic rd_check(input logic [1:0] s, input logic [7:0] i,
                            input logic [31:0] expv, input int req);
        csr_sel = s; csr_idx = i;
        #1;
        check(csr_rdata, expv, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        check(32'(seccfg_o), 32'h0, 1);
        check(32'(|entry_cfg_o), 32'h0, 1);
        check(32'(|entry_addr_o), 32'h0, 1);
        rd_check(2'd0, 8'd2, 32'h0, 1);

        for (int k = 0; k < NV; k++) begin
            wr(VEC[k].sel, VEC[k].idx, VEC[k].wdata);
            rd_check(VEC[k].sel, VEC[k].idx, VEC[k].expv, int'(VEC[k].req));
        end
        // R2 parallel output for entry 7 and entry 0
        check(32'(entry_cfg_o[8*7 +: 8]), 32'h01, 2);
        check(32'(entry_cfg_o[7:0]), 32'h07, 2);

        // R5 bypass path after a fresh reset
        do_reset();
        check(32'(entry_cfg_o[7:0]), 32'h0, 1);
        wr(2'd2, 8'd0, 32'h4);
        rd_check(2'd2, 8'd0, 32'h4, 5);
        wr(2'd0, 8'd0, 32'h00000080);
        wr(2'd0, 8'd0, 32'h00000001);
        rd_check(2'd0, 8'd0, 32'h00000001, 5);
        wr(2'd0, 8'd0, 32'h00000080);
        // R10 bypass cannot be re-enabled while locked
        wr(2'd2, 8'd0, 32'h0);
        wr(2'd2, 8'd0, 32'h4);
        rd_check(2'd2, 8'd0, 32'h0, 10);
        // R3 lock now effective
        wr(2'd0, 8'd0, 32'h00000001);
        rd_check(2'd0, 8'd0, 32'h00000080, 3);
        // R11 select 3 and config group beyond range read zero
        rd_check(2'd3, 8'd0, 32'h0, 11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule